// File: doc/BRIEF.md
# ADC Test Pattern Checker

This block sits behind a multi-channel serial ADC deserializer and verifies that the parallel samples it produces match a known test pattern driven by the converter. Each channel owns a separate checker, because each converter channel generates its pattern independently. Three patterns can be checked. The first is a ramp that rises by one code per sample. The second is a fixed synchronisation word. The third is a word supplied on an input port.

With two-wire output, each sample is split across two serial lanes. For that case the block has a lane view. The upper half of the sample is judged against the upper half of the expected word, and the lower half against the lower half. A single bad lane then costs one error, and both bad lanes cost two. This lets a capture problem on one wire be told apart from one that hits the whole sample.

Each channel reports three things. The first is a saturating error count. The second is a sticky error flag. The third is a lock indicator, which rises after a run of clean samples. The ramp checker does not fall into a cascade of errors after a slip. It takes its next expectation from what was actually received, so a single jump costs a single error and the checker locks again.

Top module: `adc_pattern_checker`

## Requirements
- R1: After reset every channel shows an error count of 0, a clear sticky flag and a low lock indicator.
- R2: With `pat_sel` = 0 (ramp), the first valid sample after reset or clear only seeds the checker and is not judged. Every later valid sample must equal the previously received sample plus one, modulo 2^14, so 16383 followed by 0 is correct.
- R3: A ramp sample that breaks the sequence adds one error. The next expectation becomes that received sample plus one, so a ramp that continues from the new value produces no further errors.
- R4: With `pat_sel` = 1 (sync), every valid sample must equal 14'b11111110000000.
- R5: With `pat_sel` = 2 (custom), every valid sample must equal `custom_word`.
- R6: With `two_wire` = 1, bits [13:7] form lane A and bits [6:0] form lane B. Each lane that differs from the same bits of the expected word adds one error, so one sample adds 0, 1 or 2. The sync word is therefore all ones on lane A and all zeros on lane B.
- R7: The lock indicator rises on the 16th consecutive judged sample that matches. It falls at the clock edge of any judged sample that mismatches.
- R8: The sticky flag is set by the first mismatch and stays set until a clear.
- R9: The error count saturates at 255 and never wraps.
- R10: A high `clr` at a clock edge zeroes the counts, sticky flags, lock indicators and clean-run tracking, and makes the ramp seed again. A sample presented in the same cycle as `clr` is discarded.
- R11: With `pat_sel` = 3 (off), valid samples are not judged, and counts, flags and lock do not change.
- R12: Channel c is taken from `in_data[c*14 +: 14]`. Errors on one channel never affect the outputs of another channel.
- R13: Cycles with `in_valid` low change nothing, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all results and ramp seeding |
| in_valid | input | 1 | Marks a cycle that carries one sample per channel |
| in_data | input | NCH*SW (56) | Packed samples, channel c at bits c*SW +: SW |
| pat_sel | input | 2 | 0 ramp, 1 sync, 2 custom, 3 off |
| two_wire | input | 1 | 1 selects per-lane judging |
| custom_word | input | SW (14) | Expected word for the custom pattern |
| err_count | output | NCH*CNT_W (32) | Saturating error count per channel, channel c at bits c*CNT_W +: CNT_W |
| err_sticky | output | NCH (4) | Sticky error flag per channel |
| locked | output | NCH (4) | Lock indicator per channel |

## Verification
A clear and a judged sample can arrive in the same cycle. Every pattern change in the bench is therefore preceded by a clear cycle that randomly carries a valid, corrupted sample on all channels. The result is correct only if the counts, flags and lock read zero afterwards. The next ramp sample must also seed the checker without being judged.

Saturation and a two-lane mismatch can also coincide. A long run of fully inverted custom words in lane view drives each count past 255 in steps of two, and the count must stop exactly at 255.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [1:0] {
    PAT_RAMP   = 2'd0,
    PAT_SYNC   = 2'd1,
    PAT_CUSTOM = 2'd2,
    PAT_OFF    = 2'd3
  } pat_e;

endpackage

// File: rtl/apc_expect.sv
module apc_expect
  import apc_pkg::*;
#(
  parameter int SW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          valid,
  input  pat_e          pat,
  input  logic [SW-1:0] custom_word,
  input  logic [SW-1:0] sample,
  output logic [SW-1:0] expected,
  output logic          check_en
);

  // Sync word: upper half of the bits set, lower half clear.
  function automatic logic [SW-1:0] sync_word();
    logic [SW-1:0] w;
    w = '0;
    for (int b = SW / 2; b < SW; b++) w[b] = 1'b1;
    return w;
  endfunction

  function automatic logic [SW-1:0] ramp_next(input logic [SW-1:0] v);
    return v + SW'(1);
  endfunction

  localparam logic [SW-1:0] SYNC_WORD = sync_word();

  logic [SW-1:0] ramp_q;
  logic          primed_q;
  logic          ramp_take;

  assign ramp_take = valid && !clr && (pat == PAT_RAMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q   <= '0;
      primed_q <= 1'b0;
    end else if (clr) begin
      primed_q <= 1'b0;
    end else if (ramp_take) begin
      ramp_q   <= ramp_next(sample);
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (pat)
      PAT_RAMP:   expected = ramp_q;
      PAT_SYNC:   expected = SYNC_WORD;
      PAT_CUSTOM: expected = custom_word;
      default:    expected = '0;
    endcase
  end

  always_comb begin
    unique case (pat)
      PAT_RAMP:   check_en = valid && !clr && primed_q;
      PAT_SYNC,
      PAT_CUSTOM: check_en = valid && !clr;
      default:    check_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/apc_compare.sv
module apc_compare #(
  parameter int SW = 14
) (
  input  logic [SW-1:0] sample,
  input  logic [SW-1:0] expected,
  input  logic          two_wire,
  output logic [1:0]    miss
);

  localparam int LO_W = SW / 2;
  localparam int HI_W = SW - LO_W;

  function automatic logic [1:0] lane_misses(input logic [SW-1:0] got,
                                             input logic [SW-1:0] want,
                                             input logic          split);
    logic hi_bad, lo_bad;
    hi_bad = got[SW-1 -: HI_W] != want[SW-1 -: HI_W];
    lo_bad = got[LO_W-1:0] != want[LO_W-1:0];
    if (split) return {1'b0, hi_bad} + {1'b0, lo_bad};
    return {1'b0, hi_bad | lo_bad};
  endfunction

  assign miss = lane_misses(sample, expected, two_wire);

endmodule

// File: rtl/apc_track.sv
module apc_track #(
  parameter int CNT_W    = 8,
  parameter int LOCK_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             check_en,
  input  logic [1:0]       miss,
  output logic [CNT_W-1:0] count,
  output logic             sticky,
  output logic             locked,
  output logic             ev_miss
);

  localparam int RUN_W = $clog2(LOCK_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_LEN);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(LOCK_LEN - 1);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [1:0]       inc);
    logic [CNT_W:0] sum;
    sum = {1'b0, a} + (CNT_W + 1)'(inc);
    return sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  endfunction

  logic [RUN_W-1:0] run_q;

  assign ev_miss = check_en && (miss != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      sticky <= 1'b0;
      locked <= 1'b0;
      run_q  <= '0;
    end else if (clr) begin
      count  <= '0;
      sticky <= 1'b0;
      locked <= 1'b0;
      run_q  <= '0;
    end else if (ev_miss) begin
      count  <= sat_add(count, miss);
      sticky <= 1'b1;
      locked <= 1'b0;
      run_q  <= '0;
    end else if (check_en && run_q != RUN_TOP) begin
      run_q  <= run_q + RUN_W'(1);
      if (run_q == RUN_PRE) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_pattern_checker.sv
module adc_pattern_checker
  import apc_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int SW       = 14,
  parameter int CNT_W    = 8,
  parameter int LOCK_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic [NCH*SW-1:0]    in_data,
  input  logic [1:0]           pat_sel,
  input  logic                 two_wire,
  input  logic [SW-1:0]        custom_word,
  output logic [NCH*CNT_W-1:0] err_count,
  output logic [NCH-1:0]       err_sticky,
  output logic [NCH-1:0]       locked
);

  pat_e pat;
  assign pat = pat_e'(pat_sel);

  // Per-channel events, exposed for the bound checker.
  logic [NCH-1:0] ev_check;
  logic [NCH-1:0] ev_miss;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] smp;
    logic [SW-1:0] expv;
    logic [1:0]    miss;

    assign smp = in_data[c*SW +: SW];

    apc_expect #(.SW(SW)) u_exp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .valid      (in_valid),
      .pat        (pat),
      .custom_word(custom_word),
      .sample     (smp),
      .expected   (expv),
      .check_en   (ev_check[c])
    );

    apc_compare #(.SW(SW)) u_cmp (
      .sample  (smp),
      .expected(expv),
      .two_wire(two_wire),
      .miss    (miss)
    );

    apc_track #(.CNT_W(CNT_W), .LOCK_LEN(LOCK_LEN)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .check_en(ev_check[c]),
      .miss    (miss),
      .count   (err_count[c*CNT_W +: CNT_W]),
      .sticky  (err_sticky[c]),
      .locked  (locked[c]),
      .ev_miss (ev_miss[c])
    );
  end

endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic [1:0]           pat_sel,
  input logic [NCH*CNT_W-1:0] err_count,
  input logic [NCH-1:0]       err_sticky,
  input logic [NCH-1:0]       locked,
  input logic [NCH-1:0]       ev_check,
  input logic [NCH-1:0]       ev_miss
);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky[c] && !clr |=> err_sticky[c]);

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_miss[c] |=> err_sticky[c]);

    // R7
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_miss[c] |=> !locked[c]);

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked[c]) |-> $past(ev_check[c]) && !$past(ev_miss[c]));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (err_count[c*CNT_W +: CNT_W] == '0) && !err_sticky[c] && !locked[c]);

    // R9
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> err_count[c*CNT_W +: CNT_W] >= $past(err_count[c*CNT_W +: CNT_W]));

    // R11
    off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_sel == 2'd3) && !clr |=> $stable(err_count[c*CNT_W +: CNT_W])
                                    && $stable(err_sticky[c]) && $stable(locked[c]));
  end

endmodule

bind adc_pattern_checker apc_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_apc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .pat_sel   (pat_sel),
  .err_count (err_count),
  .err_sticky(err_sticky),
  .locked    (locked),
  .ev_check  (ev_check),
  .ev_miss   (ev_miss)
);

// File: tb/adc_pattern_checker_tb.sv
module adc_pattern_checker_tb;
  localparam int NCH = 4;
  localparam int SW = 14;
  localparam int CNT_W = 8;
  localparam int LOCK_LEN = 16;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_MAX = 255;
  localparam logic [SW-1:0] SYNC_REF = 14'b11111110000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic [NCH*SW-1:0] in_data = '0;
  logic [1:0] pat_sel = 2'd0;
  logic two_wire = 1'b0;
  logic [SW-1:0] custom_word = '0;
  logic [NCH*CNT_W-1:0] err_count;
  logic [NCH-1:0] err_sticky;
  logic [NCH-1:0] locked;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_pattern_checker #(.NCH(NCH), .SW(SW), .CNT_W(CNT_W), .LOCK_LEN(LOCK_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .pat_sel(pat_sel), .two_wire(two_wire), .custom_word(custom_word),
    .err_count(err_count), .err_sticky(err_sticky), .locked(locked)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  // Reference state, built from the requirements.
  int m_ramp[NCH];
  bit m_seeded[NCH];
  int m_cnt[NCH];
  bit m_sticky[NCH];
  int m_run[NCH];
  bit m_lock[NCH];
  int src[NCH];

  function automatic int bad_lanes(input int got, input int want, input bit split);
    int hi_bad, lo_bad;
    hi_bad = ((got >> 7) & 'h7F) != ((want >> 7) & 'h7F);
    lo_bad = (got & 'h7F) != (want & 'h7F);
    if (split) return hi_bad + lo_bad;
    return (got != want) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int c, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s ch%0d %s: actual %0d expected %0d", tag, c, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NCH; c++) begin
      chk(cur_tag, c, "count", int'(err_count[c*CNT_W +: CNT_W]), m_cnt[c]);
      chk(cur_tag, c, "sticky", int'(err_sticky[c]), int'(m_sticky[c]));
      chk(cur_tag, c, "lock", int'(locked[c]), int'(m_lock[c]));
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < NCH; c++) begin
      int got, want, n;
      got = int'(in_data[c*SW +: SW]);
      if (clr) begin
        m_cnt[c] = 0; m_sticky[c] = 0; m_run[c] = 0; m_lock[c] = 0; m_seeded[c] = 0;
      end else if (in_valid && pat_sel != 2'd3) begin
        if (pat_sel == 2'd0 && !m_seeded[c]) begin
          m_seeded[c] = 1;
          m_ramp[c] = (got + 1) % 16384;
        end else begin
          want = (pat_sel == 2'd0) ? m_ramp[c] :
                 (pat_sel == 2'd1) ? int'(SYNC_REF) : int'(custom_word);
          n = bad_lanes(got, want, two_wire);
          if (pat_sel == 2'd0) m_ramp[c] = (got + 1) % 16384;
          if (n > 0) begin
            m_cnt[c] = (m_cnt[c] + n > CNT_MAX) ? CNT_MAX : m_cnt[c] + n;
            m_sticky[c] = 1; m_run[c] = 0; m_lock[c] = 0;
          end else begin
            if (m_run[c] < LOCK_LEN) m_run[c]++;
            if (m_run[c] >= LOCK_LEN) m_lock[c] = 1;
          end
        end
      end
    end
  endtask

  // Inputs are set at a falling edge; results are read at the next falling edge.
  task automatic cycle();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input int vpct, input int err_div, input int jump_div,
                       input logic [NCH-1:0] err_mask);
    bit v;
    v = $urandom_range(0, 99) < vpct;
    in_valid = v;
    for (int c = 0; c < NCH; c++) begin
      int w;
      if (pat_sel == 2'd0 && jump_div > 0 && $urandom_range(0, jump_div - 1) == 0)
        src[c] = $urandom_range(0, 16383);
      w = (pat_sel == 2'd0) ? src[c] : (pat_sel == 2'd1) ? int'(SYNC_REF) :
          (pat_sel == 2'd2) ? int'(custom_word) : $urandom_range(0, 16383);
      if (err_mask[c] && err_div > 0 && $urandom_range(0, err_div - 1) == 0)
        w = w ^ $urandom_range(1, 16383);
      if (!v) w = $urandom_range(0, 16383); // R13: ignored data
      in_data[c*SW +: SW] = SW'(w);
      if (v && pat_sel == 2'd0) src[c] = (src[c] + 1) % 16384;
    end
    cycle();
  endtask

  // R10: clear cycle that may carry a corrupted valid sample.
  task automatic do_clear();
    string keep;
    keep = cur_tag;
    cur_tag = "R10";
    clr = 1'b1;
    in_valid = $urandom_range(0, 1);
    for (int c = 0; c < NCH; c++) in_data[c*SW +: SW] = SW'($urandom_range(0, 16383));
    cycle();
    clr = 1'b0;
    in_valid = 1'b0;
    cur_tag = keep;
  endtask

  task automatic run_phase(input string tag, input logic [1:0] p, input bit tw, input int n,
                           input int vpct, input int err_div, input int jump_div,
                           input logic [NCH-1:0] mask);
    pat_sel = p;
    two_wire = tw;
    do_clear();
    cur_tag = tag;
    for (int i = 0; i < n; i++) drive(vpct, err_div, jump_div, mask);
  endtask

  task automatic put_all(input logic [SW-1:0] w);
    in_valid = 1'b1;
    for (int c = 0; c < NCH; c++) in_data[c*SW +: SW] = w;
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) begin
      m_ramp[c] = 0; m_seeded[c] = 0; m_cnt[c] = 0; m_sticky[c] = 0;
      m_run[c] = 0; m_lock[c] = 0; src[c] = $urandom_range(0, 16383);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R1";
    compare_all();

    // R2: clean ramp with gaps (R13), lock expected.
    run_phase("R2", 2'd0, 1'b0, 200, 75, 0, 0, '1);
    for (int c = 0; c < NCH; c++) chk("R7", c, "lock after clean ramp", int'(locked[c]), 1);

    // R2: wrap through 16383 -> 0.
    for (int c = 0; c < NCH; c++) src[c] = 16380 - c;
    run_phase("R2", 2'd0, 1'b0, 30, 100, 0, 0, '1);
    for (int c = 0; c < NCH; c++) chk("R2", c, "wrap count", int'(err_count[c*CNT_W +: CNT_W]), 0);

    // R3: directed single jump costs one error.
    for (int c = 0; c < NCH; c++) src[c] = 100;
    run_phase("R3", 2'd0, 1'b0, 20, 100, 0, 0, '1);
    for (int c = 0; c < NCH; c++) src[c] = 5000;
    cur_tag = "R3";
    for (int i = 0; i < 10; i++) drive(100, 0, 0, '1);
    for (int c = 0; c < NCH; c++) chk("R3", c, "single jump", int'(err_count[c*CNT_W +: CNT_W]), 1);

    // R3: random errors and jumps.
    run_phase("R3", 2'd0, 1'b0, 400, 80, 12, 40, '1);
    // R4 / R5.
    run_phase("R4", 2'd1, 1'b0, 300, 80, 10, 0, '1);
    custom_word = SW'($urandom_range(0, 16383));
    run_phase("R5", 2'd2, 1'b0, 300, 80, 10, 0, '1);
    // R6: lane view on every pattern.
    run_phase("R6", 2'd0, 1'b1, 300, 80, 10, 50, '1);
    run_phase("R6", 2'd1, 1'b1, 300, 80, 6, 0, '1);
    run_phase("R6", 2'd2, 1'b1, 300, 80, 6, 0, '1);

    // R6 directed: lane B wrong, then both lanes wrong.
    pat_sel = 2'd1; two_wire = 1'b1;
    do_clear();
    cur_tag = "R6";
    put_all(14'h3FFF);
    for (int c = 0; c < NCH; c++) chk("R6", c, "one lane", int'(err_count[c*CNT_W +: CNT_W]), 1);
    put_all(14'h007F);
    for (int c = 0; c < NCH; c++) chk("R6", c, "two lanes", int'(err_count[c*CNT_W +: CNT_W]), 3);

    // R12: only channel 0 sees errors.
    run_phase("R12", 2'd1, 1'b0, 200, 90, 4, 0, 4'b0001);
    for (int c = 1; c < NCH; c++) chk("R12", c, "clean neighbour", int'(err_count[c*CNT_W +: CNT_W]), 0);

    // R9: saturation with two lanes failing per sample.
    pat_sel = 2'd2; two_wire = 1'b1;
    do_clear();
    cur_tag = "R9";
    for (int i = 0; i < 140; i++) put_all(~custom_word);
    for (int c = 0; c < NCH; c++) chk("R9", c, "saturated", int'(err_count[c*CNT_W +: CNT_W]), CNT_MAX);

    // R11: off mode leaves everything as is.
    run_phase("R4", 2'd1, 1'b0, 40, 100, 5, 0, '1);
    pat_sel = 2'd3;
    cur_tag = "R11";
    for (int i = 0; i < 60; i++) drive(90, 0, 0, '1);

    // R10: clear with a bad sample, then ramp must seed again.
    pat_sel = 2'd0; two_wire = 1'b0;
    clr = 1'b1;
    cur_tag = "R10";
    put_all(14'h1234);
    clr = 1'b0;
    put_all(14'h0200);
    put_all(14'h0201);
    for (int c = 0; c < NCH; c++) chk("R10", c, "reseed", int'(err_count[c*CNT_W +: CNT_W]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule